// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block controls the two software-selected low-power states of a small 8-bit microcontroller core. The CPU writes a request bit for idle or for power-down. In idle, the CPU clock is gated off. The peripheral clock and the oscillator keep running, so the timers, the serial unit and the interrupt logic stay alive. Any enabled pending interrupt returns the core to normal running. In power-down, the oscillator enable is removed and every clock stops. Only a qualified hardware reset ends this state.

The block also drives override controls for the external bus pins while a low-power state is active. The address latch strobe and the program-store strobe are forced high in idle and low in power-down. When code runs from external program memory, port 0 is released to float in both states. Port 2 then holds the high address byte in idle and the register data in power-down. With internal execution, no port override is applied.

The raw reset pin is qualified: it must stay high for two machine cycles of the block clock before the internal reset asserts. After a reset ends power-down, the CPU clock stays gated until the oscillator reports that it is stable. The CPU, the peripherals, the oscillator and RAM retention are outside the block and are seen only through enables.

Top module: `pwr_mode_ctl`

## Requirements
- R1: `sys_rst` is 1 exactly when `rst_in` has been high at the last 2*MC_CLKS consecutive rising clock edges. After one edge with `rst_in` low, it is 0 again. A shorter pulse changes no output.
- R2: In the running state, a cycle with `wr_en`=1 and `wr_idle`=1 (and `wr_pdown`=0) enters idle at that edge, and `idle_q` reads 1.
- R3: If `wr_idle` and `wr_pdown` are both 1 in the same write, power-down is entered and `idle_q` stays 0.
- R4: In idle, `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R5: In idle, `irq_pend`=1 at a clock edge returns the block to running at that edge, and `idle_q` clears.
- R6: In power-down, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0, and `pd_q`=1. `irq_pend` does not end power-down.
- R7: `strobe_ovr`=1 in idle and in power-down, and 0 otherwise. `strobe_lvl` is 1 in idle and 0 in power-down.
- R8: In either low-power state, `p0_float` and `p2_ovr` equal `ext_code`. `p2_sel_addr` is 1 only in idle with `ext_code`=1; 0 selects register data. Outside those states all three are 0.
- R9: A qualified reset (`sys_rst`=1) in running or idle yields the running state at the next edge: both request bits are 0 and no override is active.
- R10: A qualified reset in power-down enters a wake state at the next edge. In the wake state, `osc_en`=1, `cpu_clk_en`=0, `per_clk_en`=0 and there are no overrides. The wake state ends in the running state at the first edge with `osc_stable`=1.
- R11: Writes to the request bits are ignored outside the running state: `idle_q` and `pd_q` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_in | input | 1 | Raw hardware reset pin, active high |
| wr_en | input | 1 | Write strobe for the request bits |
| wr_idle | input | 1 | Idle request bit value being written |
| wr_pdown | input | 1 | Power-down request bit value being written |
| irq_pend | input | 1 | An enabled interrupt is pending |
| osc_stable | input | 1 | Oscillator has settled |
| ext_code | input | 1 | Code is fetched from external program memory |
| sys_rst | output | 1 | Qualified reset to the core registers |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| idle_q | output | 1 | Idle request bit read value |
| pd_q | output | 1 | Power-down request bit read value |
| strobe_ovr | output | 1 | Override both bus strobes |
| strobe_lvl | output | 1 | Forced level of both bus strobes |
| p0_float | output | 1 | Release port 0 drivers |
| p2_ovr | output | 1 | Override port 2 source |
| p2_sel_addr | output | 1 | Port 2 source: 1 address byte, 0 register data |

## Verification
The assertions check on every cycle the properties that hold in each state: the clock and pin levels in idle and power-down, that power-down wins a double write, that power-down survives without reset, that reset clears both request bits, and that the wake state holds until the oscillator is stable. Only the bench's scenarios can show the exact reset qualification length and the rejection of a short pulse. The same applies to the exit of idle on an interrupt, the path from power-down through wake back to running, and ignored writes in each state, all observed at the ports.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int MC_CLKS = 12
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_in,
  input  logic wr_en,
  input  logic wr_idle,
  input  logic wr_pdown,
  input  logic irq_pend,
  input  logic osc_stable,
  input  logic ext_code,
  output logic sys_rst,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_en,
  output logic idle_q,
  output logic pd_q,
  output logic strobe_ovr,
  output logic strobe_lvl,
  output logic p0_float,
  output logic p2_ovr,
  output logic p2_sel_addr
);
  localparam int RST_CYC = 2 * MC_CLKS;
  localparam int CW = $clog2(RST_CYC + 1);

  typedef enum logic [1:0] {S_RUN, S_IDLE, S_PD, S_WAKE} st_t;
  st_t st, st_nx;
  logic [CW-1:0] rcnt;
  logic hold;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) rcnt <= '0;
    else if (!rst_in) rcnt <= '0;
    else if (rcnt != CW'(RST_CYC)) rcnt <= rcnt + CW'(1);

  assign sys_rst = (rcnt == CW'(RST_CYC));

  always_comb begin
    st_nx = st;
    if (sys_rst) begin
      case (st)
        S_PD:    st_nx = S_WAKE;
        S_WAKE:  st_nx = osc_stable ? S_RUN : S_WAKE;
        default: st_nx = S_RUN;
      endcase
    end else begin
      case (st)
        S_RUN:
          if (wr_en && wr_pdown) st_nx = S_PD;
          else if (wr_en && wr_idle) st_nx = S_IDLE;
        S_IDLE: if (irq_pend) st_nx = S_RUN;
        S_WAKE: if (osc_stable) st_nx = S_RUN;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) st <= S_RUN;
    else st <= st_nx;

  assign idle_q      = (st == S_IDLE);
  assign pd_q        = (st == S_PD);
  assign hold        = idle_q || pd_q;
  assign cpu_clk_en  = (st == S_RUN);
  assign per_clk_en  = (st == S_RUN) || idle_q;
  assign osc_en      = !pd_q;
  assign strobe_ovr  = hold;
  assign strobe_lvl  = idle_q;
  assign p0_float    = hold && ext_code;
  assign p2_ovr      = hold && ext_code;
  assign p2_sel_addr = idle_q && ext_code;
endmodule

module pwr_mode_ctl_chk (
  input logic clk,
  input logic por_n,
  input logic rst_in,
  input logic wr_en,
  input logic wr_idle,
  input logic wr_pdown,
  input logic osc_stable,
  input logic ext_code,
  input logic sys_rst,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic osc_en,
  input logic idle_q,
  input logic pd_q,
  input logic strobe_ovr,
  input logic strobe_lvl,
  input logic p0_float,
  input logic p2_ovr,
  input logic p2_sel_addr
);
  a_r1_release: assert property (@(posedge clk) disable iff (!por_n)
    !rst_in |=> !sys_rst);
  a_r1_rise: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> $past(rst_in) && rst_in);
  a_r3_pd_wins: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_clk_en && !sys_rst && wr_en && wr_idle && wr_pdown) |=> pd_q && !idle_q);
  a_r4_idle_clocks: assert property (@(posedge clk) disable iff (!por_n)
    idle_q |-> !cpu_clk_en && per_clk_en && osc_en);
  a_r6_pd_stays: assert property (@(posedge clk) disable iff (!por_n)
    (pd_q && !sys_rst) |=> pd_q);
  a_r6_pd_clocks: assert property (@(posedge clk) disable iff (!por_n)
    pd_q |-> !cpu_clk_en && !per_clk_en && !osc_en);
  a_r7_strobes: assert property (@(posedge clk) disable iff (!por_n)
    (idle_q || pd_q) |-> strobe_ovr && (strobe_lvl == idle_q));
  a_r8_ports: assert property (@(posedge clk) disable iff (!por_n)
    (idle_q || pd_q) |-> (p0_float == ext_code) && (p2_ovr == ext_code)
                         && (p2_sel_addr == (idle_q && ext_code)));
  a_r9_rst_clears: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> !idle_q && !pd_q && !strobe_ovr);
  a_r10_wake_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_clk_en && !idle_q && !pd_q && !osc_stable) |=> !cpu_clk_en && osc_en && !per_clk_en);
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_in(rst_in), .wr_en(wr_en), .wr_idle(wr_idle),
  .wr_pdown(wr_pdown), .osc_stable(osc_stable), .ext_code(ext_code),
  .sys_rst(sys_rst), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .osc_en(osc_en), .idle_q(idle_q), .pd_q(pd_q), .strobe_ovr(strobe_ovr),
  .strobe_lvl(strobe_lvl), .p0_float(p0_float), .p2_ovr(p2_ovr),
  .p2_sel_addr(p2_sel_addr)
);

// File: tb/pwr_mode_ctl_test.sv
module pwr_mode_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int MC = 12;
  localparam int RST_N = 2 * MC;

  logic clk = 0, por_n = 0, rst_in = 0, wr_en = 0, wr_idle = 0, wr_pdown = 0;
  logic irq_pend = 0, osc_stable = 1, ext_code = 0;
  logic sys_rst, cpu_clk_en, per_clk_en, osc_en, idle_q, pd_q;
  logic strobe_ovr, strobe_lvl, p0_float, p2_ovr, p2_sel_addr;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [10:0] expq[$];
  string tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl #(.MC_CLKS(MC)) uut (
    .clk(clk), .por_n(por_n), .rst_in(rst_in), .wr_en(wr_en), .wr_idle(wr_idle),
    .wr_pdown(wr_pdown), .irq_pend(irq_pend), .osc_stable(osc_stable),
    .ext_code(ext_code), .sys_rst(sys_rst), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .idle_q(idle_q), .pd_q(pd_q),
    .strobe_ovr(strobe_ovr), .strobe_lvl(strobe_lvl), .p0_float(p0_float),
    .p2_ovr(p2_ovr), .p2_sel_addr(p2_sel_addr));

  // order: cpu per osc srst idle pd sovr slvl p0f p2o p2a
  function automatic logic [10:0] e_run(logic r);
    return {1'b1, 1'b1, 1'b1, r, 7'b0};
  endfunction
  function automatic logic [10:0] e_idle(logic x, logic r);
    return {1'b0, 1'b1, 1'b1, r, 1'b1, 1'b0, 1'b1, 1'b1, x, x, x};
  endfunction
  function automatic logic [10:0] e_pd(logic x, logic r);
    return {1'b0, 1'b0, 1'b0, r, 1'b0, 1'b1, 1'b1, 1'b0, x, x, 1'b0};
  endfunction
  function automatic logic [10:0] e_wake(logic r);
    return {1'b0, 1'b0, 1'b1, r, 7'b0};
  endfunction

  function automatic logic [10:0] outs();
    return {cpu_clk_en, per_clk_en, osc_en, sys_rst, idle_q, pd_q,
            strobe_ovr, strobe_lvl, p0_float, p2_ovr, p2_sel_addr};
  endfunction

  // drive one cycle, expect outputs after the next rising edge
  task automatic step(input logic we, input logic wi, input logic wp,
                      input logic irq, input logic rs, input logic os,
                      input logic [10:0] exp, input string tag);
    @(negedge clk);
    wr_en = we; wr_idle = wi; wr_pdown = wp; irq_pend = irq; rst_in = rs; osc_stable = os;
    @(posedge clk);
    #1;
    expq.push_back(exp);
    tagq.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (expq.size() > 0) begin
      logic [10:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      n_run++;
      if (outs() !== e) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b", t, outs(), e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) por_n = 1;
    step(0,0,0,0,0,1, e_run(0), "R9 reset state running");
    // idle, internal code
    step(1,1,0,0,0,1, e_idle(0,0), "R2 R4 R7 R8 idle internal");
    step(0,0,0,0,0,1, e_idle(0,0), "R5 idle holds without irq");
    step(0,0,0,1,0,1, e_run(0), "R5 irq exits idle");
    // idle, external code
    ext_code = 1;
    step(1,1,0,0,0,1, e_idle(1,0), "R8 idle external ports");
    step(1,0,1,0,0,1, e_idle(1,0), "R11 pdown write ignored in idle");
    step(0,0,0,1,0,1, e_run(0), "R5 irq exits idle ext");
    // power-down priority
    step(1,1,1,0,0,0, e_pd(1,0), "R3 R6 R7 R8 both bits -> power-down");
    step(0,0,0,1,0,0, e_pd(1,0), "R6 irq ignored in power-down");
    step(1,1,0,0,0,0, e_pd(1,0), "R11 idle write ignored in power-down");
    // short reset pulse
    for (int i = 0; i < RST_N - 1; i++)
      step(0,0,0,0,1,0, e_pd(1,0), "R1 short pulse no reset");
    step(0,0,0,0,0,0, e_pd(1,0), "R1 short pulse released");
    // qualified reset from power-down
    for (int i = 0; i < RST_N - 1; i++)
      step(0,0,0,0,1,0, e_pd(1,0), "R1 qualifying");
    step(0,0,0,0,1,0, e_pd(1,1), "R1 reset asserts after 2 machine cycles");
    step(0,0,0,0,1,0, e_wake(1), "R10 wake after power-down reset");
    step(0,0,0,0,1,0, e_wake(1), "R10 cpu gated until osc stable");
    step(0,0,0,0,1,1, e_run(1), "R10 osc stable -> running");
    step(0,0,0,0,0,1, e_run(0), "R1 reset drops after release");
    // reset from idle
    ext_code = 0;
    step(1,1,0,0,0,1, e_idle(0,0), "R2 idle again");
    for (int i = 0; i < RST_N - 1; i++)
      step(0,0,0,0,1,1, e_idle(0,0), "R1 qualifying in idle");
    step(0,0,0,0,1,1, e_idle(0,1), "R1 reset asserts in idle");
    step(0,0,0,0,1,1, e_run(1), "R9 reset clears idle");
    step(1,1,0,0,1,1, e_run(1), "R9 write ignored under reset");
    step(0,0,0,0,0,1, e_run(0), "R9 running after reset");
    // power-down then wake with osc already stable
    step(1,0,1,0,0,1, e_pd(0,0), "R6 power-down internal");
    for (int i = 0; i < RST_N; i++)
      step(0,0,0,0,1,1, (i == RST_N-1) ? e_pd(0,1) : e_pd(0,0), "R1 qualify from pd");
    step(0,0,0,0,1,1, e_wake(1), "R10 wake state");
    step(0,0,0,0,0,1, e_run(0), "R10 wake ends on osc stable");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule